// File: doc/BRIEF.md
# Video Brightness, Contrast and Saturation Adjuster

This block applies a programmable brightness, contrast and saturation correction to an 8-bit YUV 4:2:2 sample stream. Each sample arrives with a strobe and a flag that tells whether it carries luminance or one of the two colour-difference components. Luminance is scaled about mid-grey by the contrast setting divided by 71, and the brightness setting is then added. Chrominance is scaled about the colourless point 128 by the saturation setting divided by 64.

Every result is clipped into the range 1 to 254. The extreme codes 0 and 255 are left free for timing references further down the stream. The datapath is a three-stage pipeline. It accepts one sample on every clock and delays the strobe and the flag along with the data. The three settings are captured together with the sample they apply to, so the software that writes them never has to wait for the pipeline to drain.

Top module: `vbcs_adjust`

## Requirements
- R1: When in_is_chroma is 0 (luma), out_data equals the clip of trunc((S−128)·CONT/71) + BRIG, where trunc rounds toward zero and S, CONT and BRIG are the unsigned values of in_sample, cfg_contrast and cfg_brightness.
- R2: When in_is_chroma is 1 (chroma, either Cb or Cr), out_data equals the clip of trunc((S−128)·SAT/64) + 128, where SAT is cfg_saturation. cfg_brightness has no effect on chroma.
- R3: Every output with out_valid high lies in 1..254. A value below 1 becomes 1 and a value above 254 becomes 254.
- R4: With CONT=71, SAT=64 and BRIG=128, any sample from 1 to 254 leaves unchanged on both paths. Input 0 leaves as 1 and input 255 leaves as 254.
- R5: A sample whose in_valid is high at rising edge n appears with out_valid high after rising edge n+2, which is the third edge counting edge n. out_valid is low in every other cycle.
- R6: out_is_chroma carries the in_is_chroma value of the sample that out_data belongs to.
- R7: The settings used for a sample are those present at the edge where that sample is taken in. Later changes do not affect it.
- R8: rst is synchronous and active high. After a reset edge, out_valid, out_is_chroma and out_data are all 0.
- R9: Samples on consecutive clocks are each processed and leave on consecutive clocks.
- R10: Cycles with in_valid low produce no output with out_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_is_chroma | input | 1 | 0 = luma sample, 1 = chroma sample |
| in_sample | input | 8 | Input sample code |
| cfg_contrast | input | 8 | Contrast gain, unity at 71 |
| cfg_saturation | input | 8 | Saturation gain, unity at 64 |
| cfg_brightness | input | 8 | Luma offset, neutral at 128 |
| out_valid | output | 1 | Output sample strobe |
| out_is_chroma | output | 1 | Kind flag of the output sample |
| out_data | output | 8 | Adjusted, clipped sample |

## Verification
The assertions assume that rst is held high for at least one edge before any sample is presented, and that the inputs are stable around each rising edge. They place no limit on sample or setting values, because the centred product is bounded by 128·255 for any 8-bit input. The stimulus changes inputs only on falling edges, opens with a reset, and sweeps the full 0..255 range of samples and settings, including the all-zero and all-ones extremes. It also inserts idle cycles in which the settings change while no sample is offered.

// File: rtl/vbcs_pkg.sv
package vbcs_pkg;

    localparam int PIX_W    = 8;
    localparam int MID_CODE = 128;
    localparam int LO_CODE  = 1;
    localparam int HI_CODE  = 254;

    // centred sample, signed product, magnitude and post-offset sum widths
    localparam int CENT_W = PIX_W + 1;
    localparam int PROD_W = 2 * PIX_W + 1;
    localparam int MAG_W  = PROD_W - 1;
    localparam int SUM_W  = PROD_W + 1;

    // largest product magnitude: |0 - 128| * 255
    localparam int PROD_LIM = MID_CODE * ((1 << PIX_W) - 1);

    localparam logic signed [SUM_W-1:0] LO_S = SUM_W'(LO_CODE);
    localparam logic signed [SUM_W-1:0] HI_S = SUM_W'(HI_CODE);

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic {
        SMP_LUMA   = 1'b0,
        SMP_CHROMA = 1'b1
    } smp_kind_e;

    // stage 1: sample with its own settings latched
    typedef struct packed {
        logic      valid;
        smp_kind_e kind;
        pix_t      sample;
        pix_t      gain;
        pix_t      offset;
    } cap_t;

    // stage 2: signed centred product
    typedef struct packed {
        logic                      valid;
        smp_kind_e                 kind;
        logic signed [PROD_W-1:0]  product;
        pix_t                      offset;
    } prod_t;

    function automatic logic signed [CENT_W-1:0] centre(input pix_t s);
        return $signed({1'b0, s}) - $signed(CENT_W'(MID_CODE));
    endfunction

    function automatic pix_t clip_code(input logic signed [SUM_W-1:0] v);
        if (v < LO_S)
            return pix_t'(LO_CODE);
        else if (v > HI_S)
            return pix_t'(HI_CODE);
        else
            return pix_t'(v);
    endfunction

endpackage

// File: rtl/vbcs_capture.sv
module vbcs_capture
    import vbcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_is_chroma,
    input  pix_t in_sample,
    input  pix_t cont,
    input  pix_t sat,
    input  pix_t brig,
    output cap_t cap_q
);

    // gain and offset are chosen here so later stages never see the settings
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q.valid <= in_valid;
            if (in_valid) begin
                cap_q.kind   <= in_is_chroma ? SMP_CHROMA : SMP_LUMA;
                cap_q.sample <= in_sample;
                cap_q.gain   <= in_is_chroma ? sat : cont;
                cap_q.offset <= in_is_chroma ? pix_t'(MID_CODE) : brig;
            end
        end
    end

    // R7: idle cycles leave the latched sample and settings untouched
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(cap_q.sample) && $stable(cap_q.gain)
                       && $stable(cap_q.offset)));

endmodule

// File: rtl/vbcs_scale.sv
module vbcs_scale
    import vbcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cap_t  cap_q,
    output prod_t prod_q
);

    logic signed [CENT_W-1:0] centred;
    logic signed [PROD_W-1:0] prod_c;

    always_comb begin
        centred = centre(cap_q.sample);
        prod_c  = PROD_W'(centred) * PROD_W'($signed({1'b0, cap_q.gain}));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else begin
            prod_q.valid   <= cap_q.valid;
            prod_q.kind    <= cap_q.kind;
            prod_q.product <= prod_c;
            prod_q.offset  <= cap_q.offset;
        end
    end

    // R1: the product of any 8-bit inputs stays within the signed range
    p_prod_bound_r1: assert property (@(posedge clk) disable iff (rst)
        prod_q.valid |-> ((prod_q.product <= PROD_W'(PROD_LIM))
                          && (prod_q.product >= -PROD_W'(PROD_LIM))));

endmodule

// File: rtl/vbcs_finish.sv
module vbcs_finish
    import vbcs_pkg::*;
#(
    parameter int LUMA_DIV     = 71,
    parameter int CHROMA_SHIFT = 6,
    parameter int RECIP_SHIFT  = 21,
    parameter bit USE_RECIP    = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  prod_t prod_q,
    output logic  out_valid,
    output logic  out_is_chroma,
    output pix_t  out_data
);

    logic                     neg;
    logic signed [PROD_W-1:0] flip;
    logic [MAG_W-1:0]         mag;
    logic [MAG_W-1:0]         q_luma;
    logic [MAG_W-1:0]         q_chroma;
    logic [MAG_W-1:0]         q_sel;
    logic signed [SUM_W-1:0]  q_ext;
    logic signed [SUM_W-1:0]  q_signed;
    logic signed [SUM_W-1:0]  sum;

    // work on the magnitude so the quotient truncates toward zero
    always_comb begin
        neg  = prod_q.product[PROD_W-1];
        flip = -prod_q.product;
        mag  = neg ? MAG_W'(flip) : MAG_W'(prod_q.product);
    end

    generate
        if (USE_RECIP) begin : g_recip
            // rounded-up reciprocal; error stays below one unit for |x| <= PROD_LIM
            localparam int RECIP = ((1 << RECIP_SHIFT) + LUMA_DIV - 1) / LUMA_DIV;
            localparam int RW    = $clog2(RECIP + 1);
            logic [MAG_W+RW-1:0] wide;
            assign wide   = (MAG_W+RW)'(mag) * (MAG_W+RW)'(RECIP);
            assign q_luma = MAG_W'(wide >> RECIP_SHIFT);
        end else begin : g_native
            assign q_luma = mag / MAG_W'(LUMA_DIV);
        end
    endgenerate

    always_comb begin
        q_chroma = mag >> CHROMA_SHIFT;
        q_sel    = (prod_q.kind == SMP_CHROMA) ? q_chroma : q_luma;
        q_ext    = $signed({{(SUM_W-MAG_W){1'b0}}, q_sel});
        q_signed = neg ? -q_ext : q_ext;
        sum      = q_signed + $signed({{(SUM_W-PIX_W){1'b0}}, prod_q.offset});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            out_is_chroma <= 1'b0;
            out_data      <= '0;
        end else begin
            out_valid     <= prod_q.valid;
            out_is_chroma <= (prod_q.kind == SMP_CHROMA);
            out_data      <= clip_code(sum);
        end
    end

    // R3: reserved extremes never leave the block
    p_range_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data >= pix_t'(LO_CODE)) && (out_data <= pix_t'(HI_CODE))));

    // R10: a bubble in the last stage stays a bubble
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !prod_q.valid |=> !out_valid);

endmodule

// File: rtl/vbcs_adjust.sv
module vbcs_adjust
    import vbcs_pkg::*;
#(
    parameter int LUMA_DIV     = 71,
    parameter int CHROMA_SHIFT = 6,
    parameter int RECIP_SHIFT  = 21,
    parameter bit USE_RECIP    = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_is_chroma,
    input  logic [PIX_W-1:0] in_sample,
    input  logic [PIX_W-1:0] cfg_contrast,
    input  logic [PIX_W-1:0] cfg_saturation,
    input  logic [PIX_W-1:0] cfg_brightness,
    output logic             out_valid,
    output logic             out_is_chroma,
    output logic [PIX_W-1:0] out_data
);

    cap_t  cap_q;
    prod_t prod_q;

    vbcs_capture u_capture (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_is_chroma (in_is_chroma),
        .in_sample    (in_sample),
        .cont         (cfg_contrast),
        .sat          (cfg_saturation),
        .brig         (cfg_brightness),
        .cap_q        (cap_q)
    );

    vbcs_scale u_scale (
        .clk    (clk),
        .rst    (rst),
        .cap_q  (cap_q),
        .prod_q (prod_q)
    );

    vbcs_finish #(
        .LUMA_DIV     (LUMA_DIV),
        .CHROMA_SHIFT (CHROMA_SHIFT),
        .RECIP_SHIFT  (RECIP_SHIFT),
        .USE_RECIP    (USE_RECIP)
    ) u_finish (
        .clk           (clk),
        .rst           (rst),
        .prod_q        (prod_q),
        .out_valid     (out_valid),
        .out_is_chroma (out_is_chroma),
        .out_data      (out_data)
    );

    // counts edges since reset so the latency checks look back only that far
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R5: strobe emerges exactly three edges after it entered
    p_valid_lat_r5: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R6: kind flag travels with its sample
    p_flag_lat_r6: assert property (@(posedge clk) disable iff (rst)
        ((age == 2'd3) && out_valid) |-> (out_is_chroma == $past(in_is_chroma, 3)));

    // R8: a reset edge clears every output
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_is_chroma && (out_data == '0)));

endmodule

// File: tb/vbcs_adjust_test.sv
`timescale 1ns/1ps
module vbcs_adjust_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_is_chroma = 1'b0;
    logic [7:0] in_sample = '0;
    logic [7:0] cfg_contrast = 8'd71;
    logic [7:0] cfg_saturation = 8'd64;
    logic [7:0] cfg_brightness = 8'd128;
    logic       out_valid;
    logic       out_is_chroma;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vbcs_adjust uut (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_is_chroma   (in_is_chroma),
        .in_sample      (in_sample),
        .cfg_contrast   (cfg_contrast),
        .cfg_saturation (cfg_saturation),
        .cfg_brightness (cfg_brightness),
        .out_valid      (out_valid),
        .out_is_chroma  (out_is_chroma),
        .out_data       (out_data)
    );

    // entry: {chroma, sample, gain, brightness, expected}
    localparam int NV = 18;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'd200, 8'd71,  8'd128, 8'd200},
        {1'b0, 8'd60,  8'd100, 8'd128, 8'd33 },
        {1'b0, 8'd235, 8'd142, 8'd128, 8'd254},
        {1'b0, 8'd16,  8'd142, 8'd128, 8'd1  },
        {1'b0, 8'd128, 8'd255, 8'd0,   8'd1  },
        {1'b0, 8'd129, 8'd255, 8'd10,  8'd13 },
        {1'b0, 8'd127, 8'd255, 8'd10,  8'd7  },
        {1'b1, 8'd240, 8'd64,  8'd128, 8'd240},
        {1'b1, 8'd200, 8'd100, 8'd128, 8'd240},
        {1'b1, 8'd50,  8'd100, 8'd128, 8'd7  },
        {1'b1, 8'd0,   8'd255, 8'd128, 8'd1  },
        {1'b1, 8'd255, 8'd255, 8'd128, 8'd254},
        {1'b1, 8'd127, 8'd100, 8'd128, 8'd127},
        {1'b0, 8'd0,   8'd0,   8'd255, 8'd254},
        {1'b0, 8'd255, 8'd71,  8'd128, 8'd254},
        {1'b1, 8'd100, 8'd64,  8'd0,   8'd100},
        {1'b0, 8'd255, 8'd255, 8'd255, 8'd254},
        {1'b0, 8'd0,   8'd255, 8'd0,   8'd1  }
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(input bit c, input int s, input int cont,
                                 input int sat, input int brig);
        int r;
        if (c) r = ((s - 128) * sat) / 64 + 128;
        else   r = ((s - 128) * cont) / 71 + brig;
        if (r < 1)   r = 1;
        if (r > 254) r = 254;
        return r;
    endfunction

    // entered on a falling edge; returns on the falling edge after the third rise
    task automatic run_one(input bit c, input int s, input int cont, input int sat,
                           input int brig, output int got, output bit vld, output bit flg);
        in_valid       = 1'b1;
        in_is_chroma   = c;
        in_sample      = 8'(s);
        cfg_contrast   = 8'(cont);
        cfg_saturation = 8'(sat);
        cfg_brightness = 8'(brig);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R5 not early", int'(out_valid), 0);
        @(negedge clk);
        got = int'(out_data);
        vld = out_valid;
        flg = out_is_chroma;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R5 watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int got;
        bit vld, flg;

        @(negedge clk);
        @(negedge clk);
        // R8: reset state
        check("R8 valid", int'(out_valid), 0);
        check("R8 flag", int'(out_is_chroma), 0);
        check("R8 data", int'(out_data), 0);
        rst = 1'b0;
        @(negedge clk);

        // table walk: R1 luma, R2 chroma, R3 clipping, R6 flag
        for (int i = 0; i < NV; i++) begin
            bit c;
            int s, g, b, e;
            c = VEC[i][32];
            s = int'(VEC[i][31:24]);
            g = int'(VEC[i][23:16]);
            b = int'(VEC[i][15:8]);
            e = int'(VEC[i][7:0]);
            run_one(c, s, c ? 33 : g, c ? g : 33, b, got, vld, flg);
            check("R5 valid", int'(vld), 1);
            check("R6 flag", int'(flg), int'(c));
            if (c) check("R2 chroma", got, e);
            else   check("R1 luma", got, e);
            if (e == 1 || e == 254) check("R3 clip", got, e);
        end

        // R4: neutral settings pass every legal code
        for (int s = 0; s < 256; s++) begin
            int e;
            e = (s == 0) ? 1 : ((s == 255) ? 254 : s);
            run_one(1'b0, s, 71, 64, 128, got, vld, flg);
            check("R4 luma", got, e);
            run_one(1'b1, s, 71, 64, 128, got, vld, flg);
            check("R4 chroma", got, e);
        end

        // R9 back-to-back, R7 settings change every cycle, R10 bubbles
        begin
            localparam int NS = 24;
            bit st_v [NS];
            bit st_c [NS];
            int st_e [NS];
            for (int t = 0; t < NS + 3; t++) begin
                if (t >= 3) begin
                    int k;
                    k = t - 3;
                    check("R5 R10 stream valid", int'(out_valid), int'(st_v[k]));
                    if (st_v[k]) begin
                        check("R7 R9 stream data", int'(out_data), st_e[k]);
                        check("R6 stream flag", int'(out_is_chroma), int'(st_c[k]));
                    end
                end
                if (t < NS) begin
                    int s, cn, sa, br;
                    s  = (t * 37 + 11) % 256;
                    cn = (t * 13 + 50) % 256;
                    sa = 255 - t * 9;
                    br = (t * 7 + 20) % 256;
                    st_v[t] = (t % 5) != 3;
                    st_c[t] = t[0];
                    st_e[t] = model(st_c[t], s, cn, sa, br);
                    in_valid       = st_v[t];
                    in_is_chroma   = st_c[t];
                    in_sample      = 8'(s);
                    cfg_contrast   = 8'(cn);
                    cfg_saturation = 8'(sa);
                    cfg_brightness = 8'(br);
                end else begin
                    in_valid = 1'b0;
                end
                @(negedge clk);
            end
        end

        // R8: reset while samples are in flight
        in_valid = 1'b1;
        in_is_chroma = 1'b1;
        in_sample = 8'd200;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check("R8 mid valid", int'(out_valid), 0);
        check("R8 mid flag", int'(out_is_chroma), 0);
        check("R8 mid data", int'(out_data), 0);
        rst = 1'b0;
        // R10: nothing emerges from an idle input
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            check("R10 idle", int'(out_valid), 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule